// File: doc/BRIEF.md
# Auto-Restart Protection Supervisor

This block sequences startup, normal switching and fault handling for an off-line power switch. All of its inputs are digital: flags from supply, feedback, current, voltage and temperature comparators, the measured on-time of the last gate pulse, and a pair of light-load feedback comparators. It drives three registered controls: the switching enable, the enable of the high-voltage startup current source, and a soft-start ramp value that sets the current-limit reference.

After reset the supply is charging. When the start-level flag is seen and the device is not over temperature, switching begins and the startup source is turned off. Any fault seen while switching latches switching off. The latch releases only when the supply falls to the stop level. The startup source then recharges the supply and the cycle repeats. This forms an auto-restart loop that runs until the fault goes away. A short-circuit check that depends on on-time, and a sync-sensed over-voltage check, trip only after their condition has persisted for a set number of cycles. Burst gating with hysteresis pauses switching at light load while no fault is latched.

Top module: `restart_supervisor`

## Requirements
- R1: On reset, and in the cycle after reset is released, the startup source is enabled, switching is disabled and the soft-start value is 0.
- R2: While charging, a start-level flag with the over-temperature latch clear moves the block to switching at the next edge. From then on the switching enable is 1 and the startup source enable is 0.
- R3: While switching with no fault present, a stop-level flag returns the block to charging at the next edge. The startup source is enabled again and switching stops.
- R4: A fault seen while switching clears both the switching enable and the startup source enable at the next edge. The block stays in that state, ignoring the start-level flag, until a stop-level flag moves it to charging.
- R5: The feedback-shutdown (overload) flag is a fault on its own in the cycle it is seen.
- R6: An output short is a fault when the short-threshold feedback flag is high and `on_time` is below SHORT_ON_MAX for SHORT_HOLD consecutive switching cycles. A shorter run, or an on-time at or above SHORT_ON_MAX, does not trip.
- R7: The supply over-voltage flag is a fault at once. The sync over-voltage flag is a fault only after it has been high for OVP_HOLD consecutive switching cycles.
- R8: The abnormal over-current flag is a fault only in cycles where `gate_on` is 1.
- R9: A temperature trip flag is a fault and also sets an over-temperature latch. The latch is cleared by the release flag (trip wins if both are high). While it is set, the start-level flag does not start switching.
- R10: The soft-start value is 0 in the first switching cycle. It rises by 1 every SS_DIV further switching cycles, saturates at 2^SSW-1, and returns to 0 whenever switching ends.
- R11: While switching, the burst-low flag pauses switching from the next edge (low wins if both are high). The burst-high flag resumes it. The pause is cleared whenever the block leaves switching.
- R12: Fault flags seen while charging have no effect: a later start-level flag still starts switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_start | input | 1 | Supply has reached the start level |
| vcc_stop | input | 1 | Supply has fallen to the stop level |
| fb_shutdown | input | 1 | Feedback at the overload shutdown level |
| fb_short | input | 1 | Feedback above the output-short threshold |
| on_time | input | ONW | On-time of the latest gate pulse, in cycles |
| ocp_abn | input | 1 | Abnormal over-current comparator |
| gate_on | input | 1 | Power switch gate is currently on |
| ovp_supply | input | 1 | Supply over-voltage comparator |
| ovp_sync | input | 1 | Sync-pin over-voltage comparator |
| temp_trip | input | 1 | Temperature above the shutdown point |
| temp_release | input | 1 | Temperature back below the release point |
| burst_low | input | 1 | Feedback below the burst entry level |
| burst_high | input | 1 | Feedback above the burst exit level |
| sw_en | output | 1 | Switching enable |
| start_src_en | output | 1 | Startup current source enable |
| ss_level | output | SSW | Soft-start current-limit reference |

## Verification
The bench builds the block with SHORT_HOLD=4, OVP_HOLD=3, SS_DIV=4, SSW=4 and SHORT_ON_MAX=12. With these values both persistence windows can be probed one cycle short of and exactly at their limit. The soft-start ramp can also be run to saturation within about sixty cycles. Small values make every auto-restart round trip short, so the bench can walk through each fault source, thermal hold-off, burst pause and charge-phase masking in turn. A behavioural model is compared against the design on every clock.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_LATCH  = 2'd2
  } sup_state_t;
endpackage

// File: rtl/rs_persist.sv
module rs_persist #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic cond,
  output logic trip
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  generate
    if (HOLD <= 1) begin : g_direct
      assign trip = enable && cond;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
      logic [CW-1:0] cnt;
      logic          live;

      assign live = enable && cond;
      assign trip = live && (cnt == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (!live) begin
          cnt <= '0;
        end else if (cnt != LAST) begin
          cnt <= cnt + 1'b1;
        end
      end

      // R6 R7: a trip needs the condition in the previous cycle too
      trip_needs_history_chk: assert property (@(posedge clk) disable iff (rst)
        trip |-> $past(enable && cond));
    end
  endgenerate
endmodule

// File: rtl/rs_softstart.sv
module rs_softstart #(
  parameter int SSW    = 10,
  parameter int SS_DIV = 1750
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           advance,
  output logic [SSW-1:0] level
);
  localparam int PW = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
  localparam logic [PW-1:0]  PRE_LAST = PW'(SS_DIV - 1);
  localparam logic [SSW-1:0] TOP      = '1;

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || !advance) begin
      pre   <= '0;
      level <= '0;
    end else if (pre == PRE_LAST) begin
      pre <= '0;
      if (level != TOP) level <= level + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R10: the ramp never falls while it keeps advancing
  ramp_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> (level >= $past(level)));
endmodule

// File: rtl/rs_burst.sv
module rs_burst (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic low,
  input  logic high,
  output logic paused
);
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      paused <= 1'b0;
    end else if (low) begin
      paused <= 1'b1;
    end else if (high) begin
      paused <= 1'b0;
    end
  end

  // R11: a low feedback flag during switching pauses at the next edge
  burst_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (active && low) |=> paused);
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor #(
  parameter int ONW          = 8,
  parameter int SHORT_ON_MAX = 120,
  parameter int SHORT_HOLD   = 250,
  parameter int OVP_HOLD     = 170,
  parameter int SSW          = 10,
  parameter int SS_DIV       = 1750
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vcc_start,
  input  logic           vcc_stop,
  input  logic           fb_shutdown,
  input  logic           fb_short,
  input  logic [ONW-1:0] on_time,
  input  logic           ocp_abn,
  input  logic           gate_on,
  input  logic           ovp_supply,
  input  logic           ovp_sync,
  input  logic           temp_trip,
  input  logic           temp_release,
  input  logic           burst_low,
  input  logic           burst_high,
  output logic           sw_en,
  output logic           start_src_en,
  output logic [SSW-1:0] ss_level
);
  import rs_pkg::*;

  localparam logic [ONW-1:0] ON_LIMIT = ONW'(SHORT_ON_MAX);

  sup_state_t state, state_nx;
  logic       hot;
  logic       running;
  logic       stay_run;
  logic       short_trip;
  logic       ovp_sync_trip;
  logic       fault;
  logic       paused;

  assign running = (state == ST_RUN);

  rs_persist #(.HOLD(SHORT_HOLD)) u_short (
    .clk    (clk),
    .rst    (rst),
    .enable (running),
    .cond   (fb_short && (on_time < ON_LIMIT)),
    .trip   (short_trip)
  );

  rs_persist #(.HOLD(OVP_HOLD)) u_ovp (
    .clk    (clk),
    .rst    (rst),
    .enable (running),
    .cond   (ovp_sync),
    .trip   (ovp_sync_trip)
  );

  assign fault = fb_shutdown | short_trip | ovp_sync_trip | ovp_supply |
                 (ocp_abn & gate_on) | temp_trip;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_CHARGE: if (vcc_start && !hot) state_nx = ST_RUN;
      ST_RUN: begin
        if (fault)         state_nx = ST_LATCH;
        else if (vcc_stop) state_nx = ST_CHARGE;
      end
      ST_LATCH:  if (vcc_stop) state_nx = ST_CHARGE;
      default:   state_nx = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CHARGE;
      hot   <= 1'b0;
    end else begin
      state <= state_nx;
      if (temp_trip)         hot <= 1'b1;
      else if (temp_release) hot <= 1'b0;
    end
  end

  assign stay_run = running && (state_nx == ST_RUN);

  rs_softstart #(.SSW(SSW), .SS_DIV(SS_DIV)) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .advance (stay_run),
    .level   (ss_level)
  );

  rs_burst u_burst (
    .clk    (clk),
    .rst    (rst),
    .active (stay_run),
    .low    (burst_low),
    .high   (burst_high),
    .paused (paused)
  );

  assign sw_en        = running && !paused;
  assign start_src_en = (state == ST_CHARGE);

  // R2: switching and the startup source are never on together
  src_sw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_en && start_src_en));

  // R4: a latched fault never resumes switching without recharging
  latch_no_direct_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH) |=> (state != ST_RUN));

  // R9: no start while the over-temperature latch is set
  hot_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
    (hot && state == ST_CHARGE) |=> (state != ST_RUN));

  // R5: overload during switching stops the gate at the next edge
  overload_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (running && fb_shutdown) |=> !sw_en);
endmodule

// File: tb/restart_supervisor_test.sv
module restart_supervisor_test;
  localparam int ONW = 8, ONMAX = 12, SH = 4, OH = 3, SSW = 4, DIV = 4;
  localparam int SSMAX = (1 << SSW) - 1;

  logic clk = 0, rst = 1;
  logic vcc_start = 0, vcc_stop = 0, fb_shutdown = 0, fb_short = 0;
  logic [ONW-1:0] on_time = '0;
  logic ocp_abn = 0, gate_on = 0, ovp_supply = 0, ovp_sync = 0;
  logic temp_trip = 0, temp_release = 0, burst_low = 0, burst_high = 0;
  logic sw_en, start_src_en;
  logic [SSW-1:0] ss_level;

  int checks = 0, errors = 0, cyc = 0;
  string cur = "R1";
  bit started = 0;

  // model state: 0 charge, 1 run, 2 latched
  int m_st = 0, m_sc = 0, m_oc = 0, m_ss = 0, m_pre = 0;
  bit m_hot = 0, m_pause = 0;

  restart_supervisor #(.ONW(ONW), .SHORT_ON_MAX(ONMAX), .SHORT_HOLD(SH),
    .OVP_HOLD(OH), .SSW(SSW), .SS_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .vcc_start(vcc_start), .vcc_stop(vcc_stop),
    .fb_shutdown(fb_shutdown), .fb_short(fb_short), .on_time(on_time),
    .ocp_abn(ocp_abn), .gate_on(gate_on), .ovp_supply(ovp_supply),
    .ovp_sync(ovp_sync), .temp_trip(temp_trip), .temp_release(temp_release),
    .burst_low(burst_low), .burst_high(burst_high),
    .sw_en(sw_en), .start_src_en(start_src_en), .ss_level(ss_level));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    int nx;
    bit run, sc, oc, s_trip, o_trip, flt;
    started = 1;
    if (rst) begin
      m_st = 0; m_sc = 0; m_oc = 0; m_ss = 0; m_pre = 0; m_hot = 0; m_pause = 0;
    end else begin
      run = (m_st == 1);
      sc = run && fb_short && (int'(on_time) < ONMAX);
      oc = run && ovp_sync;
      s_trip = sc && (m_sc >= SH - 1);
      o_trip = oc && (m_oc >= OH - 1);
      flt = fb_shutdown || s_trip || o_trip || ovp_supply || (ocp_abn && gate_on) || temp_trip;
      nx = m_st;
      if (m_st == 0 && vcc_start && !m_hot) nx = 1;
      else if (m_st == 1 && flt) nx = 2;
      else if (m_st == 1 && vcc_stop) nx = 0;
      else if (m_st == 2 && vcc_stop) nx = 0;
      m_sc = sc ? ((m_sc < SH - 1) ? m_sc + 1 : m_sc) : 0;
      m_oc = oc ? ((m_oc < OH - 1) ? m_oc + 1 : m_oc) : 0;
      if (run && nx == 1) begin
        if (m_pre == DIV - 1) begin
          m_pre = 0;
          if (m_ss < SSMAX) m_ss++;
        end else m_pre++;
        if (burst_low) m_pause = 1;
        else if (burst_high) m_pause = 0;
      end else begin
        m_pre = 0; m_ss = 0; m_pause = 0;
      end
      if (temp_trip) m_hot = 1;
      else if (temp_release) m_hot = 0;
      m_st = nx;
    end
  end

  always @(negedge clk) begin
    bit esw, esrc;
    if (started) begin
      esw = (m_st == 1) && !m_pause;
      esrc = (m_st == 0);
      checks++;
      if (sw_en !== esw || start_src_en !== esrc || int'(ss_level) != m_ss) begin
        errors++;
        $display("FAIL %s cycle %0d: sw_en=%b src=%b ss=%0d expected sw_en=%b src=%b ss=%0d",
                 cur, cyc, sw_en, start_src_en, ss_level, esw, esrc, m_ss);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // explicit point check from the requirements
  task automatic expect_out(string r, bit esw, bit esrc, int ess);
    checks++;
    if (sw_en !== esw || start_src_en !== esrc || int'(ss_level) != ess) begin
      errors++;
      $display("FAIL %s: sw_en=%b src=%b ss=%0d expected sw_en=%b src=%b ss=%0d",
               r, sw_en, start_src_en, ss_level, esw, esrc, ess);
    end
  endtask

  task automatic restart();
    vcc_stop = 1; tick(1); vcc_stop = 0; tick(2);
    vcc_start = 1; tick(1); vcc_start = 0; tick(6);
  endtask

  initial begin
    tick(3); rst = 0; tick(1);
    expect_out("R1", 0, 1, 0);                       // R1

    cur = "R2"; vcc_start = 1; tick(1); vcc_start = 0; tick(1);
    expect_out("R2", 1, 0, 0);                       // R2
    cur = "R10"; tick(70);
    expect_out("R10", 1, 0, SSMAX);                  // R10 saturation

    cur = "R11"; burst_low = 1; tick(1); burst_low = 0; tick(1);
    expect_out("R11", 0, 0, SSMAX);                  // R11 paused
    tick(4); burst_high = 1; tick(1); burst_high = 0; tick(1);
    expect_out("R11", 1, 0, SSMAX);                  // R11 resumed
    burst_low = 1; burst_high = 1; tick(1); burst_low = 0; burst_high = 0; tick(2);

    cur = "R3"; vcc_stop = 1; tick(1); vcc_stop = 0; tick(1);
    expect_out("R3", 0, 1, 0);                       // R3
    tick(2); vcc_start = 1; tick(1); vcc_start = 0; tick(6);

    cur = "R5"; fb_shutdown = 1; tick(1); fb_shutdown = 0; tick(1);
    expect_out("R5", 0, 0, 0);                       // R5
    cur = "R4"; vcc_start = 1; tick(3); vcc_start = 0; tick(1);
    expect_out("R4", 0, 0, 0);                       // R4 start ignored while latched
    restart();

    cur = "R6"; fb_short = 1; on_time = 8'd5; tick(3); fb_short = 0; tick(2);
    expect_out("R6", 1, 0, m_ss);                    // R6 too short a run
    fb_short = 1; on_time = 8'd12; tick(10); fb_short = 0; tick(1);
    expect_out("R6", 1, 0, m_ss);                    // R6 on-time too long
    fb_short = 1; on_time = 8'd5; tick(4); fb_short = 0; on_time = 0; tick(1);
    expect_out("R6", 0, 0, 0);                       // R6 trip
    restart();

    cur = "R7"; ovp_sync = 1; tick(2); ovp_sync = 0; tick(2);
    expect_out("R7", 1, 0, m_ss);                    // R7 below hold
    ovp_sync = 1; tick(3); ovp_sync = 0; tick(1);
    expect_out("R7", 0, 0, 0);                       // R7 sync trip
    restart();
    ovp_supply = 1; tick(1); ovp_supply = 0; tick(1);
    expect_out("R7", 0, 0, 0);                       // R7 supply trip
    restart();

    cur = "R8"; ocp_abn = 1; gate_on = 0; tick(3);
    expect_out("R8", 1, 0, m_ss);                    // R8 gate off: ignored
    gate_on = 1; tick(1); ocp_abn = 0; gate_on = 0; tick(1);
    expect_out("R8", 0, 0, 0);                       // R8 trip
    restart();

    cur = "R9"; temp_trip = 1; tick(1); temp_trip = 0;
    vcc_stop = 1; tick(1); vcc_stop = 0; tick(1);
    vcc_start = 1; tick(4);
    expect_out("R9", 0, 1, 0);                       // R9 hold-off while hot
    temp_release = 1; tick(1); temp_release = 0; tick(2); vcc_start = 0; tick(1);
    expect_out("R9", 1, 0, m_ss);                    // R9 resumes after release

    cur = "R12"; vcc_stop = 1; tick(1); vcc_stop = 0; tick(1);
    fb_shutdown = 1; fb_short = 1; on_time = 0; ovp_sync = 1; ovp_supply = 1;
    ocp_abn = 1; gate_on = 1; tick(5);
    fb_shutdown = 0; fb_short = 0; ovp_sync = 0; ovp_supply = 0; ocp_abn = 0; gate_on = 0;
    expect_out("R12", 0, 1, 0);                      // R12 still charging
    vcc_start = 1; tick(1); vcc_start = 0; tick(1);
    expect_out("R12", 1, 0, 0);                      // R12 starts normally
    tick(10);

    cur = "R1"; rst = 1; tick(2); rst = 0; tick(1);
    expect_out("R1", 0, 1, 0);                       // R1 reset from run
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule